// File: doc/BRIEF.md
# Programmable Horizontal Sync Generator

This block sits on a byte-wide 4:2:2 digital video stream that carries embedded timing reference codes, and is clocked once per sample. It looks for the four-byte timing code that marks the end of active video. On the sample after that code it restarts a horizontal position counter. From that counter it shapes one horizontal sync output. The leading and trailing edges of the output are set by two 11-bit position values. A single bit selects the polarity of the output.

A two-bit standard select sets how many samples make up one line. When no end-of-active-video code arrives, the counter wraps at that length, so the sync output keeps running on a free-running line. Edge positions are taken modulo the line length. A pulse whose end position is below its begin position therefore runs through the line boundary. This lets software move the pulse away from active video by adding (line length − N) to both positions.

Position, polarity and standard inputs behave as registers. Their values are copied into the working set only at a counter restart, so a pulse already in progress is never cut short.

Top module: `hsync_gen`

## Requirements
- R1: While reset `rstN` is low, `hsOut` is 0. Reset loads begin = 2, end = 0, non-inverted polarity and the 1716-sample line into the working set, and clears the counter to 0. After release, the counter free-runs from 0.
- R2: After input bytes 0xFF, 0x00, 0x00 and then a fourth byte with bit 4 set, the counter is 0 on the sample that follows the fourth byte. This holds whatever the other bits of the fourth byte are and wherever in the line the code arrives.
- R3: A code whose fourth byte has bit 4 clear leaves the counter running.
- R4: When begin < end, the un-inverted HS is 1 exactly for counter values c with begin ≤ c < end.
- R5: When end < begin, the un-inverted HS is 1 for c ≥ begin or c < end, so the pulse wraps through the line end.
- R6: When begin equals end, HS stays at its inactive level for the whole line.
- R7: `cfgInv` = 0 makes HS active high. `cfgInv` = 1 makes it active low, which is the logical inverse of R4–R6.
- R8: With no end-of-active-video code, the counter goes back to 0 after line length − 1. `stdSel` 0 gives 1716 samples, 1 gives 1560, 2 gives 1728 and 3 gives 1716.
- R9: Changes to `cfgBegin`, `cfgEnd`, `cfgInv` and `stdSel` have no effect until the next counter restart, whether that restart comes from a code or from a wrap. From the sample at counter value 0 onward, the new values apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous reset, active low |
| vidData | input | 8 | Video stream byte |
| stdSel | input | 2 | Line length select (0: 1716, 1: 1560, 2: 1728, 3: 1716) |
| cfgBegin | input | 11 | HS leading-edge position |
| cfgEnd | input | 11 | HS trailing-edge position |
| cfgInv | input | 1 | 1 makes HS active low |
| hsOut | output | 1 | Horizontal sync output |

## Verification
The bench records HS once per sample across whole lines and compares every sample against a window computed from the counter position.

- A one-sample pulse at position 0 shows where an end-of-active-video code lands, using fourth bytes with different unrelated bits and codes arriving mid-line. A code with bit 4 clear, arriving mid-line, would shift a one-sample pulse if it wrongly restarted the counter.
- Plain, wrapping and empty windows distinguish the two compare forms and the equal-position case. An inverted window checks polarity.
- Two-line captures under each standard code show the wrap length.
- A mid-line change of the inputs exposes any early commit, because the old pulse must persist until the wrap.

// File: rtl/hsync_pkg.sv
package hsync_pkg;

  // standard select codes
  typedef enum logic [1:0] {
    STD_NTSC = 2'd0,
    STD_SQP  = 2'd1,
    STD_PAL  = 2'd2,
    STD_ALT  = 2'd3
  } lineStd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic cntClr;   // restart horizontal counter
    logic cfgLoad;  // copy register inputs into working set
  } hsStrobe_t;

endpackage

// File: rtl/hsync_ctrl.sv
module hsync_ctrl
  import hsync_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HBIT   = 4,
  parameter int PRE_N  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] vidData,
  input  logic              lineEnd,
  output hsStrobe_t         strb
);

  localparam logic [DATA_W-1:0] SYNC_ONES  = {DATA_W{1'b1}};
  localparam logic [DATA_W-1:0] SYNC_ZEROS = '0;

  // histQ[0] is the previous byte, histQ[PRE_N-1] the oldest
  logic [DATA_W-1:0] histQ [PRE_N];
  logic [PRE_N-1:0]  preMatch;
  logic              eavHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PRE_N; i++) histQ[i] <= '0;
    end else begin
      histQ[0] <= vidData;
      for (int i = 1; i < PRE_N; i++) histQ[i] <= histQ[i-1];
    end
  end

  // preamble: oldest byte all ones, the rest all zeros
  genvar g;
  generate
    for (g = 0; g < PRE_N; g++) begin : gPre
      if (g == PRE_N - 1) begin : gOnes
        assign preMatch[g] = (histQ[g] == SYNC_ONES);
      end else begin : gZeros
        assign preMatch[g] = (histQ[g] == SYNC_ZEROS);
      end
    end
  endgenerate

  // only the H flag of the status byte matters
  assign eavHit = (&preMatch) && vidData[HBIT];

  always_comb begin
    strb.cntClr  = eavHit || lineEnd;
    strb.cfgLoad = eavHit || lineEnd;
  end

endmodule

// File: rtl/hsync_dp.sv
module hsync_dp
  import hsync_pkg::*;
#(
  parameter int   CNT_W      = 11,
  parameter int   NTSC_TOTAL = 1716,
  parameter int   SQP_TOTAL  = 1560,
  parameter int   PAL_TOTAL  = 1728,
  parameter int   HSB_DEF    = 2,
  parameter int   HSE_DEF    = 0,
  parameter logic INV_DEF    = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  hsStrobe_t        strb,
  input  logic [1:0]       cfgStd,
  input  logic [CNT_W-1:0] cfgBegin,
  input  logic [CNT_W-1:0] cfgEnd,
  input  logic             cfgInv,
  output logic             lineEnd,
  output logic [CNT_W-1:0] lineCnt,
  output logic [CNT_W-1:0] lineTot,
  output logic [CNT_W-1:0] hsbAct,
  output logic [CNT_W-1:0] hseAct,
  output logic             invAct,
  output logic             hsOut
);

  localparam logic [CNT_W-1:0] TOT_NTSC = CNT_W'(NTSC_TOTAL);
  localparam logic [CNT_W-1:0] TOT_SQP  = CNT_W'(SQP_TOTAL);
  localparam logic [CNT_W-1:0] TOT_PAL  = CNT_W'(PAL_TOTAL);
  localparam logic [CNT_W-1:0] HSB_RST  = CNT_W'(HSB_DEF);
  localparam logic [CNT_W-1:0] HSE_RST  = CNT_W'(HSE_DEF);

  logic [1:0] stdAct;
  logic       inWin;

  // working register set, refreshed only on restart
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsbAct <= HSB_RST;
      hseAct <= HSE_RST;
      invAct <= INV_DEF;
      stdAct <= STD_NTSC;
    end else if (strb.cfgLoad) begin
      hsbAct <= cfgBegin;
      hseAct <= cfgEnd;
      invAct <= cfgInv;
      stdAct <= cfgStd;
    end
  end

  always_comb begin
    case (stdAct)
      STD_SQP: lineTot = TOT_SQP;
      STD_PAL: lineTot = TOT_PAL;
      default: lineTot = TOT_NTSC;
    endcase
  end

  // horizontal position counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             lineCnt <= '0;
    else if (strb.cntClr)  lineCnt <= '0;
    else                   lineCnt <= lineCnt + 1'b1;
  end

  assign lineEnd = (lineCnt == lineTot - 1'b1);

  // window compare, wrapping when end precedes begin
  always_comb begin
    if (hsbAct <= hseAct) inWin = (lineCnt >= hsbAct) && (lineCnt < hseAct);
    else                  inWin = (lineCnt >= hsbAct) || (lineCnt < hseAct);
  end

  assign hsOut = inWin ^ invAct;

endmodule

// File: rtl/hsync_gen.sv
module hsync_gen #(
  parameter int   DATA_W     = 8,
  parameter int   CNT_W      = 11,
  parameter int   HBIT       = 4,
  parameter int   NTSC_TOTAL = 1716,
  parameter int   SQP_TOTAL  = 1560,
  parameter int   PAL_TOTAL  = 1728,
  parameter int   HSB_DEF    = 2,
  parameter int   HSE_DEF    = 0,
  parameter logic INV_DEF    = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] vidData,
  input  logic [1:0]        stdSel,
  input  logic [CNT_W-1:0]  cfgBegin,
  input  logic [CNT_W-1:0]  cfgEnd,
  input  logic              cfgInv,
  output logic              hsOut
);

  hsync_pkg::hsStrobe_t strb;
  logic             lineEnd;
  logic [CNT_W-1:0] lineCnt;
  logic [CNT_W-1:0] lineTot;
  logic [CNT_W-1:0] hsbAct;
  logic [CNT_W-1:0] hseAct;
  logic             invAct;

  hsync_ctrl #(
    .DATA_W (DATA_W),
    .HBIT   (HBIT),
    .PRE_N  (3)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .vidData (vidData),
    .lineEnd (lineEnd),
    .strb    (strb)
  );

  hsync_dp #(
    .CNT_W      (CNT_W),
    .NTSC_TOTAL (NTSC_TOTAL),
    .SQP_TOTAL  (SQP_TOTAL),
    .PAL_TOTAL  (PAL_TOTAL),
    .HSB_DEF    (HSB_DEF),
    .HSE_DEF    (HSE_DEF),
    .INV_DEF    (INV_DEF)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .cfgStd   (stdSel),
    .cfgBegin (cfgBegin),
    .cfgEnd   (cfgEnd),
    .cfgInv   (cfgInv),
    .lineEnd  (lineEnd),
    .lineCnt  (lineCnt),
    .lineTot  (lineTot),
    .hsbAct   (hsbAct),
    .hseAct   (hseAct),
    .invAct   (invAct),
    .hsOut    (hsOut)
  );

endmodule

// File: rtl/hsync_gen_chk.sv
module hsync_gen_chk
  import hsync_pkg::*;
#(
  parameter int   DATA_W  = 8,
  parameter int   CNT_W   = 11,
  parameter int   HBIT    = 4,
  parameter int   HSB_DEF = 2,
  parameter int   HSE_DEF = 0,
  parameter logic INV_DEF = 1'b0
) (
  input logic              clk,
  input logic              rstN,
  input logic [DATA_W-1:0] vidData,
  input hsStrobe_t         strb,
  input logic [CNT_W-1:0]  lineCnt,
  input logic [CNT_W-1:0]  lineTot,
  input logic [CNT_W-1:0]  hsbAct,
  input logic [CNT_W-1:0]  hseAct,
  input logic              invAct,
  input logic              hsOut
);

  // edges since reset release, saturating at 3
  logic [1:0] ageQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ageQ <= '0;
    else if (ageQ != 2'd3)  ageQ <= ageQ + 1'b1;
  end

  AST_RST_DEFAULTS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (hsbAct == CNT_W'(HSB_DEF) && hseAct == CNT_W'(HSE_DEF)
                     && invAct == INV_DEF && lineCnt == '0 && hsOut == INV_DEF)); // R1

  AST_EAV_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (ageQ == 2'd3 && $past(vidData, 3) == {DATA_W{1'b1}} && $past(vidData, 2) == '0
     && $past(vidData, 1) == '0 && vidData[HBIT]) |=> (lineCnt == '0)); // R2

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntClr |=> (lineCnt == $past(lineCnt) + 1'b1)); // R3

  AST_EMPTY_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (hsbAct == hseAct) |-> (hsOut == invAct)); // R6

  AST_CNT_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rstN)
    lineCnt < lineTot); // R8

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cfgLoad |=> ($stable(hsbAct) && $stable(hseAct)
                       && $stable(invAct) && $stable(lineTot))); // R9

endmodule

bind hsync_gen hsync_gen_chk #(
  .DATA_W  (DATA_W),
  .CNT_W   (CNT_W),
  .HBIT    (HBIT),
  .HSB_DEF (HSB_DEF),
  .HSE_DEF (HSE_DEF),
  .INV_DEF (INV_DEF)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .vidData (vidData),
  .strb    (strb),
  .lineCnt (lineCnt),
  .lineTot (lineTot),
  .hsbAct  (hsbAct),
  .hseAct  (hseAct),
  .invAct  (invAct),
  .hsOut   (hsOut)
);

// File: tb/hsync_gen_tb.sv
`timescale 1ns/1ps
module hsync_gen_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b1;
  logic [7:0]  vidData = 8'h80;
  logic [1:0]  stdSel = 2'd0;
  logic [10:0] cfgBegin = 11'd2;
  logic [10:0] cfgEnd = 11'd0;
  logic        cfgInv = 1'b0;
  logic        hsOut;

  int nChk = 0;
  int nFail = 0;
  logic capQ [0:4095];

  hsync_gen u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .vidData  (vidData),
    .stdSel   (stdSel),
    .cfgBegin (cfgBegin),
    .cfgEnd   (cfgEnd),
    .cfgInv   (cfgInv),
    .hsOut    (hsOut)
  );

  always #2.5 clk = ~clk;

  // sample away from the edge, then present the next byte
  task automatic tick(input logic [7:0] b, output logic s);
    @(negedge clk);
    s = hsOut;
    vidData = b;
  endtask

  task automatic sendCode(input logic [7:0] xy, input int idx);
    logic s;
    tick(8'hFF, s); capQ[idx]   = s;
    tick(8'h00, s); capQ[idx+1] = s;
    tick(8'h00, s); capQ[idx+2] = s;
    tick(xy,    s); capQ[idx+3] = s;
  endtask

  task automatic capture(input int from, input int n);
    for (int c = from; c < from + n; c++) begin
      logic s;
      tick(8'h80, s);
      capQ[c] = s;
    end
  endtask

  task automatic setCfg(input int b, input int e, input logic inv, input logic [1:0] sd);
    cfgBegin = 11'(b);
    cfgEnd   = 11'(e);
    cfgInv   = inv;
    stdSel   = sd;
  endtask

  function automatic logic expHs(input int c, input int b, input int e, input logic inv);
    logic w;
    if (b <= e) w = (c >= b) && (c < e);
    else        w = (c >= b) || (c < e);
    return w ^ inv;
  endfunction

  // capQ[from..from+n-1] holds counter positions (idx - base) mod total
  task automatic checkCap(input string req, input int from, input int n, input int base,
                          input int total, input int b, input int e, input logic inv);
    int bad = -1;
    logic expV = 1'b0;
    for (int c = from; c < from + n; c++) begin
      logic ev;
      ev = expHs((c - base) % total, b, e, inv);
      if (bad < 0 && capQ[c] !== ev) begin
        bad = c;
        expV = ev;
      end
    end
    nChk++;
    if (bad >= 0) begin
      nFail++;
      $display("FAIL %s: sample %0d actual %0b expected %0b", req, bad, capQ[bad], expV);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic expV);
    nChk++;
    if (act !== expV) begin
      nFail++;
      $display("FAIL %s: actual %0b expected %0b", req, act, expV);
    end
  endtask

  task automatic testReset;
    repeat (3) @(negedge clk);
    checkBit("R1 hs idle in reset", hsOut, 1'b0);
    @(negedge clk);
    checkBit("R1 hs idle at release", hsOut, 1'b0);
    rstN = 1'b1;
    capture(1, 1716);
    checkCap("R1 defaults free-run", 1, 1716, 0, 1716, 2, 0, 1'b0);
  endtask

  task automatic testEavRestart;
    setCfg(0, 1, 1'b0, 2'd0);
    sendCode(8'h9D, 4092);
    capture(0, 60);
    checkCap("R2 eav xy=9D", 0, 60, 0, 1716, 0, 1, 1'b0);
    capture(0, 333);
    sendCode(8'hF1, 4092);
    capture(0, 60);
    checkCap("R2 eav xy=F1 mid-line", 0, 60, 0, 1716, 0, 1, 1'b0);
    capture(0, 1000);
    sendCode(8'hB0, 4092);
    capture(0, 60);
    checkCap("R2 eav xy=B0 mid-line", 0, 60, 0, 1716, 0, 1, 1'b0);
  endtask

  task automatic testSavIgnored;
    setCfg(5, 6, 1'b0, 2'd0);
    sendCode(8'h9D, 4092);
    capture(0, 50);
    sendCode(8'hAB, 50);
    capture(54, 150);
    checkCap("R3 sav ignored", 0, 204, 0, 1716, 5, 6, 1'b0);
  endtask

  task automatic runLine(input string req, input int b, input int e, input logic inv);
    setCfg(b, e, inv, 2'd0);
    sendCode(8'h9D, 4092);
    capture(0, 1716);
    checkCap(req, 0, 1716, 0, 1716, b, e, inv);
  endtask

  task automatic testLineLength(input logic [1:0] sd, input int total);
    setCfg(5, 6, 1'b0, sd);
    sendCode(8'h9D, 4092);
    capture(0, 2 * total + 10);
    checkCap("R8 free-run wrap", 0, 2 * total + 10, 0, total, 5, 6, 1'b0);
  endtask

  task automatic testDeferred;
    setCfg(10, 20, 1'b0, 2'd0);
    sendCode(8'h9D, 4092);
    capture(0, 100);
    setCfg(300, 310, 1'b1, 2'd0);
    capture(100, 2 * 1716 - 100);
    checkCap("R9 old cfg held to line end", 0, 1716, 0, 1716, 10, 20, 1'b0);
    checkCap("R9 new cfg after wrap", 1716, 1716, 1716, 1716, 300, 310, 1'b1);
  endtask

  initial begin
    #1 rstN = 1'b0;
    testReset();
    testEavRestart();
    testSavIgnored();
    runLine("R4 plain window", 100, 400, 1'b0);
    runLine("R4 near-full window", 0, 1715, 1'b0);
    runLine("R5 wrapped window", 1700, 30, 1'b0);
    runLine("R5 shift away by 20", 1698, 1696, 1'b0);
    runLine("R6 empty window", 700, 700, 1'b0);
    runLine("R7 inverted polarity", 100, 400, 1'b1);
    testLineLength(2'd0, 1716);
    testLineLength(2'd1, 1560);
    testLineLength(2'd2, 1728);
    testLineLength(2'd3, 1716);
    testDeferred();
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    #750000;
    nChk++;
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule